// File: doc/BRIEF.md
# Incrementer-Corrected Carry-Skip Adder

This block is a purely combinational binary adder that takes two N-bit operands and a carry input and returns an N-bit sum and a carry output. The operand width is cut into equal groups of M bits. The lowest group is a plain ripple-carry adder fed by the external carry. Each higher group adds its operand slices with a ripple-carry adder whose carry input is held at zero, so every group forms its local result at the same time. A chain of half adders then adds the real incoming carry to that provisional sum.

A group's carry output comes from a two-way selector. When every bit of the group has exactly one operand bit set, the whole group propagates, and the selector forwards the incoming carry. Otherwise the selector forwards the group's own ripple carry, which then does not depend on the carry input. The carry into each group therefore moves through one selector per group. The skip path also never waits for a zero carry to ripple through a group's adder.

The block is meant to be used as an arithmetic building block. It can be instantiated anywhere from 8 bits up to 256 bits wide, and N must be a whole multiple of M.

Top module: `csa_incr_skip_adder`

## Requirements
- R1: For every operand pair and carry input, {co, sum} equals opa + opb + ci, computed at N+1 bits.
- R2: When every bit of a group has opa[i] XOR opb[i] equal to 1, the group's carry output equals the carry entering that group, and the bits above the group see that carry unchanged.
- R3: When at least one bit of a group has opa[i] XOR opb[i] equal to 0, the group's carry output equals the carry that the group's operand slices produce with a zero carry input, whatever carry enters the group.
- R4: The lowest M bits of sum equal the low M bits of opa[M-1:0] + opb[M-1:0] + ci.
- R5: In every group above the lowest, an incoming carry of 1 raises that group's sum slice by exactly one modulo 2^M, compared with the same slice added with a zero carry.
- R6: With opb equal to the bitwise inverse of opa, the result is sum = all ones and co = 0 when ci = 0, and sum = 0 and co = 1 when ci = 1.
- R7: The same structure gives correct results for any N that is a multiple of M. The widths exercised are 8 bits with 4-bit groups, 64 bits with 8-bit groups and 256 bits with 16-bit groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input     | N     | First operand |
| opb  | input     | N     | Second operand |
| ci   | input     | 1     | Carry input into the lowest group |
| sum  | output    | N     | Sum bits |
| co   | output    | 1     | Carry output of the most significant group's selector |

## Verification
At 8 bits the bench tries every one of the 2^17 input combinations. It splits the results by whether the low group propagates, so two kinds of error show up as a wrong upper nibble or a wrong co: a selector that picks the wrong source, and a group that lets its generate depend on the incoming carry. A defective increment chain, for example one that drops a carry between half adders, shows up as a wrong upper slice whenever a carry of 1 arrives at a group. The all-propagate patterns (opb = ~opa) and the all-ones plus carry pattern force the carry through every skip selector. A mishandled skip then gives an all-ones sum where zero is expected, or the reverse. Random operands at 64 and 256 bits catch faults in the group indexing that only appear when there are many groups.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef enum logic {
    SEL_GROUP  = 1'b0,
    SEL_BYPASS = 1'b1
  } skip_sel_e;

endpackage

// File: rtl/csa_ripple_group.sv
module csa_ripple_group #(
  parameter int unsigned M = 4
) (
  input  logic [M-1:0] ga,
  input  logic [M-1:0] gb,
  input  logic         gcin,
  output logic [M-1:0] gsum,
  output logic         gcout,
  output logic         gprop
);

  logic [M:0]   carry;
  logic [M-1:0] bitp;

  assign carry[0] = gcin;

  for (genvar i = 0; i < M; i++) begin : g_bit
    assign bitp[i]     = ga[i] ^ gb[i];
    assign gsum[i]     = bitp[i] ^ carry[i];
    assign carry[i+1]  = (ga[i] & gb[i]) | (bitp[i] & carry[i]);
  end

  assign gcout = carry[M];
  assign gprop = &bitp;

  // R2
  always_comb begin
    if (gprop) begin
      rip_pass_chk: assert (gcout == gcin);
    end
  end

endmodule

// File: rtl/csa_increment_chain.sv
module csa_increment_chain #(
  parameter int unsigned M = 4
) (
  input  logic [M-1:0] psum,
  input  logic         inc,
  output logic [M-1:0] fsum
);

  logic [M-1:0] hc;

  assign hc[0] = inc;

  for (genvar i = 0; i < M; i++) begin : g_ha
    assign fsum[i] = psum[i] ^ hc[i];
    if (i < M - 1) begin : g_carry
      assign hc[i+1] = psum[i] & hc[i];
    end
  end

  // R5
  always_comb begin
    inc_step_chk: assert (fsum == M'(psum + M'(inc)));
  end

endmodule

// File: rtl/csa_skip_mux.sv
module csa_skip_mux
  import csa_pkg::*;
(
  input  logic prop,
  input  logic cin_in,
  input  logic rca_cout,
  output logic cout
);

  skip_sel_e sel;

  always_comb begin
    sel = prop ? SEL_BYPASS : SEL_GROUP;
    unique case (sel)
      SEL_BYPASS: cout = cin_in;
      default:    cout = rca_cout;
    endcase
  end

endmodule

// File: rtl/csa_incr_skip_adder.sv
module csa_incr_skip_adder #(
  parameter int unsigned N = 8,
  parameter int unsigned M = 4
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         ci,
  output logic [N-1:0] sum,
  output logic         co
);

  localparam int unsigned GROUPS = N / M;

  logic [GROUPS:0]   gcarry;
  logic [GROUPS-1:0] gprop;
  logic [GROUPS-1:0] rca_co;

  assign gcarry[0] = ci;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [M-1:0] sa;
    logic [M-1:0] sb;
    logic [M-1:0] psum;

    assign sa = opa[g*M +: M];
    assign sb = opb[g*M +: M];

    if (g == 0) begin : g_first
      csa_ripple_group #(.M(M)) u_rca (
        .ga(sa), .gb(sb), .gcin(ci),
        .gsum(psum), .gcout(rca_co[g]), .gprop(gprop[g])
      );
      assign sum[g*M +: M] = psum;
    end else begin : g_later
      logic [M-1:0] fsum;
      csa_ripple_group #(.M(M)) u_rca (
        .ga(sa), .gb(sb), .gcin(1'b0),
        .gsum(psum), .gcout(rca_co[g]), .gprop(gprop[g])
      );
      csa_increment_chain #(.M(M)) u_inc (
        .psum(psum), .inc(gcarry[g]), .fsum(fsum)
      );
      assign sum[g*M +: M] = fsum;
    end

    csa_skip_mux u_mux (
      .prop(gprop[g]), .cin_in(gcarry[g]),
      .rca_cout(rca_co[g]), .cout(gcarry[g+1])
    );

    // R3
    always_comb begin
      logic [M:0] gen_sum;
      gen_sum = {1'b0, sa} + {1'b0, sb};
      if (!gprop[g]) begin
        grp_generate_chk: assert (gcarry[g+1] == gen_sum[M]);
      end
    end
  end

  assign co = gcarry[GROUPS];

  // R1
  always_comb begin
    full_sum_chk: assert ({co, sum} == ({1'b0, opa} + {1'b0, opb} + (N+1)'(ci)));
  end

  // R6
  always_comb begin
    if (&(opa ^ opb)) begin
      all_prop_chk: assert (co == ci);
    end
  end

endmodule

// File: tb/sim_csa_incr_skip_adder.sv
module sim_csa_incr_skip_adder;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic [7:0]   a0, b0, s0;
  logic         c0, co0;
  logic [63:0]  a1, b1, s1;
  logic         c1, co1;
  logic [255:0] a2, b2, s2;
  logic         c2, co2;

  csa_incr_skip_adder #(.N(8), .M(4)) u0 (
    .opa(a0), .opb(b0), .ci(c0), .sum(s0), .co(co0));
  csa_incr_skip_adder #(.N(64), .M(8)) u1 (
    .opa(a1), .opb(b1), .ci(c1), .sum(s1), .co(co1));
  csa_incr_skip_adder #(.N(256), .M(16)) u2 (
    .opa(a2), .opb(b2), .ci(c2), .sum(s2), .co(co2));

  task automatic chk(input string req, input logic [256:0] got, input logic [256:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive_all(input logic [255:0] a, input logic [255:0] b, input logic c);
    @(posedge clk);
    a0 <= a[7:0];  b0 <= b[7:0];  c0 <= c;
    a1 <= a[63:0]; b1 <= b[63:0]; c1 <= c;
    a2 <= a;       b2 <= b;       c2 <= c;
    @(negedge clk);
  endtask

  task automatic check_wide(input string req);
    logic [64:0]  e1;
    logic [256:0] e2;
    e1 = {1'b0, a1} + {1'b0, b1} + 65'(c1);
    e2 = {1'b0, a2} + {1'b0, b2} + 257'(c2);
    chk(req, 257'({co1, s1}), 257'(e1));
    chk(req, {co2, s2}, e2);
  endtask

  initial begin
    a0 = '0; b0 = '0; c0 = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    a2 = '0; b2 = '0; c2 = 1'b0;
    @(negedge clk);
    chk("R1 zero inputs", 257'({co0, s0}), 257'(0));

    // exhaustive 8-bit sweep
    for (int i = 0; i < 131072; i++) begin
      int ea, eb, ec, full, lo, gen, hi_in, hi;
      @(posedge clk);
      {c0, a0, b0} <= i[16:0];
      @(negedge clk);
      ea = int'(a0); eb = int'(b0); ec = int'(c0);
      full = ea + eb + ec;
      chk("R1 exhaustive", 257'({co0, s0}), 257'(full));
      lo = (ea & 15) + (eb & 15) + ec;
      chk("R4 low group", 257'(s0[3:0]), 257'(lo & 15));
      gen = ((ea & 15) + (eb & 15)) >> 4;
      if (((ea ^ eb) & 15) == 15) begin
        hi_in = ec;
        chk("R2 skip passes carry", 257'({co0, s0[7:4]}), 257'((ea >> 4) + (eb >> 4) + hi_in));
      end else begin
        hi_in = gen;
        chk("R3 generate ignores ci", 257'({co0, s0[7:4]}), 257'((ea >> 4) + (eb >> 4) + hi_in));
      end
      if (hi_in == 1) begin
        hi = (((ea >> 4) + (eb >> 4)) & 15);
        chk("R5 increment by one", 257'(s0[7:4]), 257'((hi + 1) & 15));
      end
    end

    // all-propagate corners at every width
    for (int r = 0; r < 8; r++) begin
      logic [255:0] v;
      v = rnd256();
      drive_all(v, ~v, 1'b0);
      chk("R6 prop ci=0 w8", 257'({co0, s0}), 257'({1'b0, 8'hFF}));
      chk("R6 prop ci=0 w64", 257'({co1, s1}), 257'({1'b0, {64{1'b1}}}));
      chk("R6 prop ci=0 w256", {co2, s2}, {1'b0, {256{1'b1}}});
      drive_all(v, ~v, 1'b1);
      chk("R6 prop ci=1 w8", 257'({co0, s0}), 257'({1'b1, 8'h00}));
      chk("R6 prop ci=1 w64", 257'({co1, s1}), 257'({1'b1, 64'h0}));
      chk("R6 prop ci=1 w256", {co2, s2}, {1'b1, 256'h0});
    end

    // full-length ripple through every group
    drive_all({256{1'b1}}, '0, 1'b1);
    check_wide("R7 all ones plus carry");
    drive_all({256{1'b1}}, {256{1'b1}}, 1'b1);
    check_wide("R7 all ones both");

    // random wide patterns
    for (int r = 0; r < 3000; r++) begin
      drive_all(rnd256(), rnd256(), 1'($urandom));
      check_wide("R7 random wide");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule